// File: doc/BRIEF.md
# EPROM Mode Decoder and Array

This block is a synthesizable behavioural stand-in for a one-time or UV-erasable byte-wide program memory. It is meant to sit in a testbench as a target for a memory controller, or inside a chip as an emulation of an external program store. Analog levels and access delays are left out. Every control combination is decoded on the same cycle it is applied, and a read result appears combinationally on the data bus.

The control inputs are active-low chip select, active-low output enable and active-low program strobe. Two flags stand in for voltage conditions: one says the programming supply is raised, and one says a high voltage is present on address line nine. From these the decoder picks one of standby, output-off, program, read, verify and identifier. A program pulse can only clear bits, so the stored byte becomes the old value ANDed with the bus value. In identifier mode the block returns one of two fixed bytes, chosen by address bit 0. A separate erase input returns every byte to all-ones, in the same way that exposure to light does on the real part.

The address width is a parameter. The default of 10 bits keeps elaboration small. Setting it to 17 gives the full 128K-byte array.

Top module: `eprom_emul`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every byte reads 0xFF.
- R2: With ce_n high, dq_oe is 0 whatever the values of oe_n, prog_n and the flags, and no byte changes.
- R3: With ce_n low, oe_n high and no program condition, dq_oe is 0.
- R4: With ce_n low, oe_n low, vpp_hi low and a9_hv low, dq_oe is 1 and dq_out is the byte stored at addr.
- R5: With ce_n low, oe_n high and vpp_hi high, a 1-to-0 transition of prog_n writes dq_in once at the next clock edge. Holding prog_n low does not write again, and only the addressed byte changes.
- R6: A program write stores old AND dq_in. A bit that is 0 never returns to 1 through programming.
- R7: A program strobe has no effect while ce_n is high or vpp_hi is low.
- R8: With ce_n low, oe_n low, vpp_hi high and prog_n high (verify), dq_oe is 1 and dq_out is the stored byte. If prog_n is low in that combination, dq_oe is 0.
- R9: With ce_n low, oe_n low, vpp_hi low and a9_hv high (identifier), dq_out is 0x20 when addr[0] is 0 and 0x05 when addr[0] is 1. When vpp_hi is high, a9_hv is ignored and verify applies.
- R10: sig_addr_err is 1 exactly when identifier mode is active and some address bit other than bit 0 and bit 9 is 1. In that case dq_out is unspecified.
- R11: erase_all high at a clock edge sets every byte to 0xFF. If a program write falls on the same edge, the erase wins and the write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset, fills the array with ones |
| addr | input | ADDR_W | Byte address |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| prog_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming supply raised |
| a9_hv | input | 1 | High voltage present on address line nine |
| erase_all | input | 1 | Return every byte to 0xFF |
| dq_in | input | 8 | Data to program |
| dq_out | output | 8 | Read, verify or identifier data |
| dq_oe | output | 1 | Data bus drive enable |
| sig_addr_err | output | 1 | Identifier access with stray address bits |

## Verification
Erase and program can hit the same clock edge. The bench provokes this by raising erase_all in the very cycle where the program strobe falls on a byte that is already partly cleared. The result is judged by reading that byte and a second byte afterwards: both must read 0xFF, which shows the erase won and the write was dropped. Identifier and verify share the same output-enable conditions and differ only in the supply flag. The bench therefore raises both flags together and expects the stored byte, not an identifier.

// File: rtl/eprom_emul_pkg.sv
// Package eprom_emul_pkg
// Shared mode encoding and fixed identifier bytes for the EPROM emulation.
// Assumes an 8-bit data word throughout.
package eprom_emul_pkg;
    localparam int DATA_W = 8;
    localparam logic [DATA_W-1:0] ID_MAKER  = 8'h20;
    localparam logic [DATA_W-1:0] ID_DEVICE = 8'h05;

    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_OUT_OFF,
        MD_PROGRAM,
        MD_READ,
        MD_VERIFY,
        MD_IDENT,
        MD_ILLEGAL
    } mode_e;
endpackage

// File: rtl/eprom_mode_dec.sv
// Module eprom_mode_dec
// Decodes the control pins into one operating mode. It produces a single-cycle
// write strobe on the falling edge of prog_n in program mode, and flags an
// identifier access made with stray address bits.
// Assumes all control inputs are synchronous to clk.
module eprom_mode_dec
    import eprom_emul_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              prog_n,
    input  logic              vpp_hi,
    input  logic              a9_hv,
    output mode_e             mode,
    output logic              wr_stb,
    output logic              sig_bad
);
    localparam logic [ADDR_W-1:0] SIG_KEEP =
        (ADDR_W > 9) ? (ADDR_W'(1) | (ADDR_W'(1) << 9)) : ADDR_W'(1);

    logic prog_q;

    // Pick the operating mode from the control pins.
    always_comb begin
        mode = MD_STANDBY;
        if (!ce_n) begin
            if (oe_n)
                mode = (vpp_hi && !prog_n) ? MD_PROGRAM : MD_OUT_OFF;
            else if (vpp_hi)
                mode = prog_n ? MD_VERIFY : MD_ILLEGAL;
            else if (a9_hv)
                mode = MD_IDENT;
            else
                mode = MD_READ;
        end
    end

    // Remember the last strobe level so a write happens only once per low pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) prog_q <= 1'b1;
        else        prog_q <= prog_n;
    end

    // Write strobe and stray-address flag.
    always_comb begin
        wr_stb  = (mode == MD_PROGRAM) && prog_q;
        sig_bad = (mode == MD_IDENT) && (|(addr & ~SIG_KEEP));
    end

    assert_wr_needs_supply_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (!ce_n && oe_n && vpp_hi));
    assert_single_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);
    assert_sigerr_scope_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sig_bad |-> (a9_hv && !vpp_hi && !ce_n && !oe_n));
endmodule

// File: rtl/eprom_cell_array.sv
// Module eprom_cell_array
// Byte array whose writes can only clear bits. Reset or erase fills every byte
// with ones in one cycle, and erase takes priority over a write on the same edge.
// Assumes the read port is combinational on addr.
module eprom_cell_array
    import eprom_emul_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Fill with ones on reset or erase, otherwise AND the new data into the byte.
    always_ff @(posedge clk) begin
        if (!rst_n || erase) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (wr_en) begin
            mem[addr] <= mem[addr] & wr_data;
        end
    end

    // Combinational read of the addressed byte.
    assign rd_data = mem[addr];

    assert_no_bit_rises_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !erase) |=> ((mem[$past(addr)] & ~$past(rd_data)) == '0));
    assert_erase_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && erase) |=> (mem[$past(addr)] == '1));
    assert_erase_fills_R11: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> (mem[0] == '1 && mem[DEPTH-1] == '1));
endmodule

// File: rtl/eprom_out_stage.sv
// Module eprom_out_stage
// Selects what the data bus carries in each mode and whether it is driven.
// Assumes the mode is already decoded. Returns zero whenever it does not drive.
module eprom_out_stage
    import eprom_emul_pkg::*;
(
    input  mode_e             mode,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              addr_lsb,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    // Bus source per mode.
    always_comb begin
        dq_out = '0;
        dq_oe  = 1'b0;
        unique case (mode)
            MD_READ, MD_VERIFY: begin
                dq_out = rd_data;
                dq_oe  = 1'b1;
            end
            MD_IDENT: begin
                dq_out = addr_lsb ? ID_DEVICE : ID_MAKER;
                dq_oe  = 1'b1;
            end
            default: begin
                dq_out = '0;
                dq_oe  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/eprom_emul.sv
// Module eprom_emul
// Top of the EPROM emulation: a mode decoder, a clear-only byte array and an
// output selector. Outputs follow the inputs combinationally, and array changes
// take effect at the next rising edge of clk.
// Assumes ADDR_W >= 10 when the address-nine identifier rule is to apply fully.
module eprom_emul
    import eprom_emul_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              prog_n,
    input  logic              vpp_hi,
    input  logic              a9_hv,
    input  logic              erase_all,
    input  logic [7:0]        dq_in,
    output logic [7:0]        dq_out,
    output logic              dq_oe,
    output logic              sig_addr_err
);
    mode_e             mode;
    logic              wr_stb;
    logic [DATA_W-1:0] rd_data;

    eprom_mode_dec #(.ADDR_W(ADDR_W)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .prog_n  (prog_n),
        .vpp_hi  (vpp_hi),
        .a9_hv   (a9_hv),
        .mode    (mode),
        .wr_stb  (wr_stb),
        .sig_bad (sig_addr_err)
    );

    eprom_cell_array #(.ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .erase   (erase_all),
        .wr_en   (wr_stb),
        .addr    (addr),
        .wr_data (dq_in),
        .rd_data (rd_data)
    );

    eprom_out_stage u_out (
        .mode     (mode),
        .rd_data  (rd_data),
        .addr_lsb (addr[0]),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe)
    );

    assert_standby_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !dq_oe);
    assert_disable_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n) |-> !dq_oe);
    assert_ident_bytes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && a9_hv && !vpp_hi) |-> (dq_out == (addr[0] ? 8'h05 : 8'h20)));
endmodule

// File: tb/eprom_emul_bench.sv
`timescale 1ns/1ps
module eprom_emul_bench;
    typedef struct packed {
        logic       ce_n;
        logic       oe_n;
        logic       prog_n;
        logic       vpp;
        logic       hv;
        logic       ers;
        logic [9:0] addr;
        logic [7:0] din;
        logic       eoe;
        logic       cd;
        logic [7:0] edat;
        logic       eerr;
        logic [3:0] req;
    } vec_t;

    function automatic vec_t mk(input logic [5:0] c, input int a, input int d,
                                input logic eoe, input logic cd, input int ed,
                                input logic ee, input int rq);
        vec_t v;
        {v.ce_n, v.oe_n, v.prog_n, v.vpp, v.hv, v.ers} = c;
        v.addr = 10'(a);
        v.din  = 8'(d);
        v.eoe  = eoe;
        v.cd   = cd;
        v.edat = 8'(ed);
        v.eerr = ee;
        v.req  = 4'(rq);
        return v;
    endfunction

    // control bits: {ce_n, oe_n, prog_n, vpp_hi, a9_hv, erase_all}
    localparam int NV = 43;
    localparam vec_t VECS [NV] = '{
        mk(6'b001000, 5, 0, 1, 1, 'hFF, 0, 1),      // R1 erased byte reads ones
        mk(6'b101000, 5, 0, 0, 0, 0, 0, 2),         // R2 standby, oe low
        mk(6'b111000, 5, 0, 0, 0, 0, 0, 2),         // R2 standby, oe high
        mk(6'b011000, 5, 0, 0, 0, 0, 0, 3),         // R3 output off
        mk(6'b011100, 5, 'hA5, 0, 0, 0, 0, 5),      // R5 program setup
        mk(6'b010100, 5, 'hA5, 0, 0, 0, 0, 5),      // R5 strobe falls
        mk(6'b011100, 5, 'hA5, 0, 0, 0, 0, 5),      // R5 strobe release
        mk(6'b001100, 5, 0, 1, 1, 'hA5, 0, 8),      // R8 verify
        mk(6'b001000, 5, 0, 1, 1, 'hA5, 0, 4),      // R4 normal read
        mk(6'b011100, 5, 'h3C, 0, 0, 0, 0, 6),      // R6 setup
        mk(6'b010100, 5, 'h3C, 0, 0, 0, 0, 6),      // R6 strobe
        mk(6'b011100, 5, 'h3C, 0, 0, 0, 0, 6),      // R6 release
        mk(6'b001100, 5, 0, 1, 1, 'h24, 0, 6),      // R6 A5 AND 3C
        mk(6'b011100, 5, 'hFF, 0, 0, 0, 0, 6),      // R6 try to set bits
        mk(6'b010100, 5, 'hFF, 0, 0, 0, 0, 6),      // R6
        mk(6'b011100, 5, 'hFF, 0, 0, 0, 0, 6),      // R6
        mk(6'b001000, 5, 0, 1, 1, 'h24, 0, 6),      // R6 zeros stay
        mk(6'b111100, 5, 0, 0, 0, 0, 0, 7),         // R7 deselected
        mk(6'b110100, 5, 0, 0, 0, 0, 0, 7),         // R7 strobe while deselected
        mk(6'b111100, 5, 0, 0, 0, 0, 0, 7),         // R7
        mk(6'b001000, 5, 0, 1, 1, 'h24, 0, 7),      // R7 unchanged
        mk(6'b011000, 5, 0, 0, 0, 0, 0, 7),         // R7 supply low
        mk(6'b010000, 5, 0, 0, 0, 0, 0, 7),         // R7 strobe with supply low
        mk(6'b011000, 5, 0, 0, 0, 0, 0, 7),         // R7
        mk(6'b001000, 5, 0, 1, 1, 'h24, 0, 7),      // R7 unchanged
        mk(6'b001000, 6, 0, 1, 1, 'hFF, 0, 5),      // R5 neighbour untouched
        mk(6'b011100, 7, 'hF0, 0, 0, 0, 0, 5),      // R5 setup
        mk(6'b010100, 7, 'hF0, 0, 0, 0, 0, 5),      // R5 strobe falls
        mk(6'b010100, 7, 'h0F, 0, 0, 0, 0, 5),      // R5 held low, new data
        mk(6'b011100, 7, 'h0F, 0, 0, 0, 0, 5),      // R5 release
        mk(6'b001000, 7, 0, 1, 1, 'hF0, 0, 5),      // R5 one write per pulse
        mk(6'b000100, 7, 0, 0, 0, 0, 0, 8),         // R8 verify with strobe low
        mk(6'b001010, 'h200, 0, 1, 1, 'h20, 0, 9),  // R9 maker byte
        mk(6'b001010, 'h201, 0, 1, 1, 'h05, 0, 9),  // R9 device byte
        mk(6'b001010, 'h001, 0, 1, 1, 'h05, 0, 9),  // R9 device byte
        mk(6'b001010, 'h003, 0, 1, 0, 0, 1, 10),    // R10 stray bit 1
        mk(6'b001010, 'h080, 0, 1, 0, 0, 1, 10),    // R10 stray bit 7
        mk(6'b001110, 5, 0, 1, 1, 'h24, 0, 9),      // R9 supply high wins
        mk(6'b001000, 3, 0, 1, 1, 'hFF, 0, 10),     // R10 no flag in read
        mk(6'b011100, 5, 0, 0, 0, 0, 0, 11),        // R11 setup
        mk(6'b010101, 5, 0, 0, 0, 0, 0, 11),        // R11 strobe with erase
        mk(6'b001000, 5, 0, 1, 1, 'hFF, 0, 11),     // R11 erase won
        mk(6'b001000, 7, 0, 1, 1, 'hFF, 0, 11)      // R11 other byte erased
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] addr = '0;
    logic       ce_n = 1'b1, oe_n = 1'b1, prog_n = 1'b1;
    logic       vpp_hi = 1'b0, a9_hv = 1'b0, erase_all = 1'b0;
    logic [7:0] dq_in = '0;
    logic [7:0] dq_out;
    logic       dq_oe;
    logic       sig_addr_err;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    eprom_emul #(.ADDR_W(10)) u_eprom_emul (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr         (addr),
        .ce_n         (ce_n),
        .oe_n         (oe_n),
        .prog_n       (prog_n),
        .vpp_hi       (vpp_hi),
        .a9_hv        (a9_hv),
        .erase_all    (erase_all),
        .dq_in        (dq_in),
        .dq_out       (dq_out),
        .dq_oe        (dq_oe),
        .sig_addr_err (sig_addr_err)
    );

    task automatic step(input vec_t v, input int idx);
        @(negedge clk);
        {ce_n, oe_n, prog_n, vpp_hi, a9_hv, erase_all} =
            {v.ce_n, v.oe_n, v.prog_n, v.vpp, v.hv, v.ers};
        addr  = v.addr;
        dq_in = v.din;
        #5;
        n_run++;
        if (dq_oe !== v.eoe || sig_addr_err !== v.eerr ||
            (v.cd && dq_out !== v.edat)) begin
            n_fail++;
            $display("FAIL R%0d step %0d: oe=%0b data=%02h err=%0b expected oe=%0b data=%02h err=%0b",
                     v.req, idx, dq_oe, dq_out, sig_addr_err, v.eoe, v.edat, v.eerr);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(mk(6'b110000, 0, 0, 0, 0, 0, 0, 1), 100);      // R1 idle after reset
        for (int i = 0; i < NV; i++) step(VECS[i], i);
        // R1: program a byte, reset, expect ones again
        step(mk(6'b011100, 9, 0, 0, 0, 0, 0, 5), 200);
        step(mk(6'b010100, 9, 0, 0, 0, 0, 0, 5), 201);
        step(mk(6'b011100, 9, 0, 0, 0, 0, 0, 5), 202);
        step(mk(6'b001000, 9, 0, 1, 1, 'h00, 0, 5), 203);   // R5 cleared
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        step(mk(6'b001000, 9, 0, 1, 1, 'hFF, 0, 1), 204);   // R1 ones after reset
        // R11: erase alone while deselected
        step(mk(6'b011100, 2, 'h11, 0, 0, 0, 0, 5), 210);
        step(mk(6'b010100, 2, 'h11, 0, 0, 0, 0, 5), 211);
        step(mk(6'b011100, 2, 'h11, 0, 0, 0, 0, 5), 212);
        step(mk(6'b001000, 2, 0, 1, 1, 'h11, 0, 4), 213);   // R4 programmed byte
        step(mk(6'b110001, 2, 0, 0, 0, 0, 0, 11), 214);     // R11 erase pulse
        step(mk(6'b001000, 2, 0, 1, 1, 'hFF, 0, 11), 215);  // R11 restored
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule